// File: doc/BRIEF.md
# Display Channel Plane Priority Packer

This block turns a per-channel set of hardware overlay planes into the two values a display compositor needs for one channel: a 32-bit priority word and a hardware plane mask. Software loads a small configuration record for each plane through a slot-addressed write port. Each record holds a visible flag, a flag saying the plane belongs to this channel, a depth value, a hardware plane index and a flag for a two-plane (two-buffer) pixel format. A compute strobe then starts a sequential stable insertion sort of the qualifying planes by depth. A single-cycle packing stage builds the priority word and mask from the sorted list, and `done` pulses for one cycle when the new values appear.

The block also keeps the group-level word that binds each hardware plane to one of the two timing channels in the pair. When a compute ends, the new mask is merged into that binding. An odd channel claims its planes and an even channel releases them. The binding is rewritten only if the merge changes it, and a one-cycle restart request is raised when a change happens while any channel of the group is in use, or when the caller has a restart pending. A fixed-mapping mode replaces the sorted result with one preset plane per channel. A setup strobe clears the priority word so that every plane starts disabled.

Top module: `plane_prio_packer`

## Requirements
- R1: A plane enters the result only when both its visible flag and its on-channel flag are 1 at compute time. Planes missing either flag leave no nibble and no mask bit.
- R2: Included planes are ordered by ascending depth value. Planes with equal depth keep ascending configuration-slot order.
- R3: Each included plane takes one 4-bit slot, and a two-plane format takes two. With S slots in total, the k-th slot of the sorted list (k from 0) goes into nibble S-1-k, which is bits [4(S-1-k)+3 : 4(S-1-k)]. The first sorted plane therefore sits in the highest used nibble, and slots whose nibble number would be 8 or more are dropped.
- R4: A slot's nibble value is its hardware index plus one, and bit [hardware index] of the 8-bit plane mask is set. Mask bits are set even for slots dropped under R3.
- R5: A plane with a two-plane format takes a second slot directly after its first. That slot uses hardware index (index+1) mod 8.
- R6: With `fixed_map`=1 the sorted result is replaced. With `fixed_gen_new`=0, channel parity p gives priority p+1 and mask 1<<p. With `fixed_gen_new`=1, an odd channel gives priority 3 with mask 0x04 and an even channel gives priority 1 with mask 0x01.
- R7: At the end of each compute the 16-bit binding becomes binding OR mask for an odd channel (`chan_is_odd`=1), and binding AND NOT mask for an even channel.
- R8: `assign_word` always shows the 16-bit binding in both halves. `restart_req` pulses in the `done` cycle when the binding changed and `group_in_use`=1, or when `restart_pending`=1. It stays 0 in all other cycles.
- R9: A `setup_clr` pulse while idle sets the priority word to 0 on the next edge. The plane mask and the binding are left unchanged.
- R10: With no included planes, the priority word and the plane mask are both 0.
- R11: `done` is a one-cycle pulse no more than 64 cycles after an accepted `compute`. While `busy`=1, `compute`, `setup_clr` and configuration writes are ignored. Between `done` pulses the priority word and mask change only through `setup_clr`.
- R12: After reset, `prio_word`, `plane_mask`, `assign_word`, `done`, `busy` and `restart_req` are all 0, and every plane record is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one plane record |
| cfg_slot | input | 3 | Record slot written |
| cfg_visible | input | 1 | Plane visible flag |
| cfg_on_chan | input | 1 | Plane belongs to this channel |
| cfg_zpos | input | 4 | Plane depth value |
| cfg_hwidx | input | 3 | Hardware plane index |
| cfg_dual | input | 1 | Two-plane pixel format |
| chan_is_odd | input | 1 | Channel parity (1 = odd channel) |
| fixed_map | input | 1 | Replace the result with the preset mapping |
| fixed_gen_new | input | 1 | Selects the newer preset table |
| group_in_use | input | 1 | Some channel of the group is running |
| restart_pending | input | 1 | Forces a restart request at the next done |
| setup_clr | input | 1 | Clear the priority word |
| compute | input | 1 | Start a sort and pack |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle pulse: outputs updated |
| prio_word | output | 32 | Packed priority word |
| plane_mask | output | 8 | Hardware plane mask |
| assign_word | output | 32 | Channel binding, 16 bits in both halves |
| restart_req | output | 1 | One-cycle group restart request |

## Verification
A corrupted sort entry or count shows up in `prio_word` as a wrong or shifted nibble at the `done` pulse that ends the compute where it happened, and in `plane_mask` as a missing or extra bit. A wrong binding register shows up in `assign_word` straight away and stays until the next compute with a differing mask. It also shows up as a missing or extra `restart_req` in the same `done` cycle. The vectors cover equal depths, two-plane wrap from index 7 to 0, more than eight slots, and every preset mapping, so an off-by-one in the placement or the wrap is caught at the first `done` that uses it.

// File: rtl/ppk_pkg.sv
// Package: shared constants and the plane configuration record for the
// plane priority packer. Assumes hardware indices fit in a nibble minus one.
package ppk_pkg;

    localparam int ZPOS_W  = 4;              // depth value width
    localparam int HWIDX_W = 3;              // hardware plane index width
    localparam int NIB_W   = 4;              // priority nibble width
    localparam int MASK_W  = 1 << HWIDX_W;   // one mask bit per hardware plane

    typedef struct packed {
        logic               visible;
        logic               on_chan;
        logic [ZPOS_W-1:0]  zpos;
        logic [HWIDX_W-1:0] hwidx;
        logic               dual;
    } plane_cfg_t;

    // A plane takes part only if it is shown and bound to this channel.
    function automatic logic plane_included(input plane_cfg_t p);
        return p.visible & p.on_chan;
    endfunction

endpackage

// File: rtl/ppk_cfg_bank.sv
// Module: ppk_cfg_bank
// Holds one configuration record per plane slot. A write lands at the next
// edge unless the hold input is high (a sort is running). Assumes wr_slot
// is below NUM_PLANES; writes to higher slots are dropped.
module ppk_cfg_bank
    import ppk_pkg::*;
#(
    parameter int NUM_PLANES = 8,
    localparam int PID_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             hold,
    input  logic [PID_W-1:0] wr_slot,
    input  plane_cfg_t       wr_data,
    output plane_cfg_t       cfg [NUM_PLANES]
);

    genvar g;
    generate
        for (g = 0; g < NUM_PLANES; g++) begin : g_slot
            // Purpose: store the record of slot g when it is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[g] <= '0;
                end else if (wr_en && !hold && (wr_slot == PID_W'(g))) begin
                    cfg[g] <= wr_data;
                end
            end
        end
    endgenerate

    // A write while held must leave the addressed record untouched.
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && wr_en) |=> $stable(cfg[0])) else $error("cfg written while held"); // R11

endmodule

// File: rtl/ppk_sorter.sv
// Module: ppk_sorter
// Sequential stable insertion sort of the included plane slots by depth.
// One slot is examined per SCAN cycle, and each SHIFT cycle does one
// compare and at most one move. sort_done pulses one cycle after the last
// slot has been handled. order[0..count-1] then holds the slot numbers in
// ascending depth; equal depths keep ascending slot order. Assumes cfg is
// held constant while busy.
module ppk_sorter
    import ppk_pkg::*;
#(
    parameter int NUM_PLANES = 8,
    localparam int PID_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
    localparam int CNT_W = $clog2(NUM_PLANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  plane_cfg_t       cfg [NUM_PLANES],
    output logic             busy,
    output logic             sort_done,
    output logic [PID_W-1:0] order [NUM_PLANES],
    output logic [CNT_W-1:0] count
);

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SHIFT} sort_state_t;

    localparam logic [PID_W-1:0] LAST_SLOT = PID_W'(NUM_PLANES - 1);

    sort_state_t      state;
    logic [PID_W-1:0] scan_i;
    logic [PID_W-1:0] cand;
    logic [CNT_W-1:0] pos_j;
    logic [PID_W-1:0] prev_id;
    logic             move_up;

    // Purpose: look up the entry just above the insertion point and decide
    // whether the candidate still has to pass it.
    always_comb begin
        prev_id = order[PID_W'(pos_j - 1'b1)];
        move_up = (pos_j != '0) && (cfg[prev_id].zpos > cfg[cand].zpos);
    end

    assign busy = (state != S_IDLE);

    // Purpose: sort state machine, insertion list and slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            scan_i    <= '0;
            cand      <= '0;
            pos_j     <= '0;
            count     <= '0;
            sort_done <= 1'b0;
            for (int k = 0; k < NUM_PLANES; k++) order[k] <= '0;
        end else begin
            sort_done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        scan_i <= '0;
                        count  <= '0;
                        state  <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (plane_included(cfg[scan_i])) begin
                        cand  <= scan_i;
                        pos_j <= count;
                        state <= S_SHIFT;
                    end else if (scan_i == LAST_SLOT) begin
                        sort_done <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        scan_i <= scan_i + 1'b1;
                    end
                end
                S_SHIFT: begin
                    if (move_up) begin
                        order[PID_W'(pos_j)] <= prev_id;
                        pos_j                <= pos_j - 1'b1;
                    end else begin
                        order[PID_W'(pos_j)] <= cand;
                        count                <= count + 1'b1;
                        if (scan_i == LAST_SLOT) begin
                            sort_done <= 1'b1;
                            state     <= S_IDLE;
                        end else begin
                            scan_i <= scan_i + 1'b1;
                            state  <= S_SCAN;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // The list can never hold more entries than there are slots.
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= NUM_PLANES) else $error("sort count overflow"); // R1
    // The completion flag is a single-cycle pulse.
    AST_SORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sort_done |=> !sort_done) else $error("sort_done stretched"); // R11
    // Completion only follows the active states.
    AST_SORT_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sort_done |-> $past(busy)) else $error("sort_done from idle"); // R11

endmodule

// File: rtl/ppk_pack.sv
// Module: ppk_pack
// Builds the priority word and plane mask from the sorted list in one
// combinational pass and registers them on commit. Slot k of S goes into
// nibble S-1-k; nibbles past the word are dropped, but their mask bits are
// kept. The preset mapping replaces the packed result when fixed_map is set.
// mask_next is exported for the binding tracker. Assumes HWIDX_W < NIB_W.
module ppk_pack
    import ppk_pkg::*;
#(
    parameter int NUM_PLANES = 8,
    parameter int WORD_W     = 32,
    localparam int PID_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
    localparam int CNT_W = $clog2(NUM_PLANES + 1),
    localparam int NIBS  = WORD_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  plane_cfg_t        cfg [NUM_PLANES],
    input  logic [PID_W-1:0]  order [NUM_PLANES],
    input  logic [CNT_W-1:0]  count,
    input  logic              fixed_map,
    input  logic              fixed_gen_new,
    input  logic              chan_odd,
    input  logic              commit,
    input  logic              setup_clr,
    output logic [MASK_W-1:0] mask_next,
    output logic [WORD_W-1:0] prio_word,
    output logic [MASK_W-1:0] plane_mask
);

    logic [WORD_W-1:0] word_c;
    logic [MASK_W-1:0] mask_c;

    // Purpose: count slots, then place each slot's nibble and mask bit.
    always_comb begin
        int                 total;
        int                 pos;
        plane_cfg_t         pc;
        logic [HWIDX_W-1:0] hw;
        word_c = '0;
        mask_c = '0;
        total  = 0;
        pc     = '0;
        hw     = '0;
        for (int k = 0; k < NUM_PLANES; k++) begin
            if (k < int'(count)) total += cfg[order[k]].dual ? 2 : 1;
        end
        pos = total;
        for (int k = 0; k < NUM_PLANES; k++) begin
            if (k < int'(count)) begin
                pc  = cfg[order[k]];
                hw  = pc.hwidx;
                pos = pos - 1;
                if (pos < NIBS) word_c[pos*NIB_W +: NIB_W] = NIB_W'(hw) + 1'b1;
                mask_c[hw] = 1'b1;
                if (pc.dual) begin
                    hw  = hw + 1'b1;
                    pos = pos - 1;
                    if (pos < NIBS) word_c[pos*NIB_W +: NIB_W] = NIB_W'(hw) + 1'b1;
                    mask_c[hw] = 1'b1;
                end
            end
        end
        if (fixed_map) begin
            word_c = '0;
            mask_c = '0;
            if (fixed_gen_new) begin
                word_c[NIB_W-1:0] = chan_odd ? NIB_W'(3) : NIB_W'(1);
                mask_c[chan_odd ? 2 : 0] = 1'b1;
            end else begin
                word_c[NIB_W-1:0] = chan_odd ? NIB_W'(2) : NIB_W'(1);
                mask_c[chan_odd ? 1 : 0] = 1'b1;
            end
        end
    end

    assign mask_next = mask_c;

    // Purpose: output registers, loaded on commit and cleared by setup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_word  <= '0;
            plane_mask <= '0;
        end else if (commit) begin
            prio_word  <= word_c;
            plane_mask <= mask_c;
        end else if (setup_clr) begin
            prio_word  <= '0;
        end
    end

    // Outside commit and setup, the outputs hold.
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !setup_clr) |=> ($stable(prio_word) && $stable(plane_mask)))
        else $error("outputs moved without commit"); // R11
    // The preset mapping always yields exactly one plane.
    AST_FIXED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && fixed_map) |=> ($countones(plane_mask) == 1))
        else $error("preset mask not one-hot"); // R6
    // A setup clear leaves the mask alone.
    AST_SETUP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_clr && !commit) |=> (prio_word == '0 && $stable(plane_mask)))
        else $error("setup clear misbehaved"); // R9

endmodule

// File: rtl/ppk_assign.sv
// Module: ppk_assign
// Keeps the group binding of planes to the two timing channels. On commit,
// an odd channel ORs its mask in and an even channel clears it out. The
// restart request pulses with the commit if the binding changed while the
// group is in use, or if a restart is pending. Assumes MASK_W <= HALF_W.
module ppk_assign
    import ppk_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              chan_odd,
    input  logic [MASK_W-1:0] mask_next,
    input  logic              group_in_use,
    input  logic              restart_pending,
    output logic [2*HALF_W-1:0] assign_word,
    output logic              restart_req
);

    logic [HALF_W-1:0] bind_q;
    logic [HALF_W-1:0] bind_d;
    logic [HALF_W-1:0] mask_ext;

    // Purpose: merge the new mask into the binding according to parity.
    always_comb begin
        mask_ext = HALF_W'(mask_next);
        bind_d   = chan_odd ? (bind_q | mask_ext) : (bind_q & ~mask_ext);
    end

    // Purpose: binding register and restart request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bind_q      <= '0;
            restart_req <= 1'b0;
        end else if (commit) begin
            bind_q      <= bind_d;
            restart_req <= ((bind_d != bind_q) && group_in_use) || restart_pending;
        end else begin
            restart_req <= 1'b0;
        end
    end

    assign assign_word = {bind_q, bind_q};

    // Odd channel only ever adds planes to the binding.
    AST_ODD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && chan_odd) |=> ((bind_q & $past(bind_q)) == $past(bind_q)))
        else $error("odd channel dropped planes"); // R7
    // Even channel only ever removes planes from the binding.
    AST_EVEN_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !chan_odd) |=> ((bind_q & ~$past(bind_q)) == '0))
        else $error("even channel added planes"); // R7
    // A restart request only follows a commit.
    AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> $past(commit)) else $error("stray restart"); // R8
    // The binding moves only at a commit.
    AST_BIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bind_q)) else $error("binding moved"); // R8

endmodule

// File: rtl/plane_prio_packer.sv
// Module: plane_prio_packer (top)
// Plane priority packer for one display channel: configuration bank,
// insertion sorter, packing stage and channel binding tracker. compute and
// setup_clr are accepted only while idle; done pulses one cycle after the
// sort completes, together with the new outputs and any restart request.
module plane_prio_packer
    import ppk_pkg::*;
#(
    parameter int NUM_PLANES = 8,
    parameter int WORD_W     = 32,
    parameter int HALF_W     = 16,
    localparam int PID_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
    localparam int CNT_W = $clog2(NUM_PLANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [PID_W-1:0]    cfg_slot,
    input  logic                cfg_visible,
    input  logic                cfg_on_chan,
    input  logic [ZPOS_W-1:0]   cfg_zpos,
    input  logic [HWIDX_W-1:0]  cfg_hwidx,
    input  logic                cfg_dual,
    input  logic                chan_is_odd,
    input  logic                fixed_map,
    input  logic                fixed_gen_new,
    input  logic                group_in_use,
    input  logic                restart_pending,
    input  logic                setup_clr,
    input  logic                compute,
    output logic                busy,
    output logic                done,
    output logic [WORD_W-1:0]   prio_word,
    output logic [MASK_W-1:0]   plane_mask,
    output logic [2*HALF_W-1:0] assign_word,
    output logic                restart_req
);

    plane_cfg_t       cfg [NUM_PLANES];
    plane_cfg_t       wr_rec;
    logic [PID_W-1:0] order [NUM_PLANES];
    logic [CNT_W-1:0] count;
    logic [MASK_W-1:0] mask_next;
    logic             sort_busy;
    logic             sort_done;
    logic             start;
    logic             setup_ok;

    assign wr_rec   = '{visible: cfg_visible, on_chan: cfg_on_chan, zpos: cfg_zpos,
                        hwidx: cfg_hwidx, dual: cfg_dual};
    assign busy     = sort_busy | sort_done;
    assign start    = compute & ~busy;
    assign setup_ok = setup_clr & ~busy;

    ppk_cfg_bank #(.NUM_PLANES(NUM_PLANES)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .hold    (busy),
        .wr_slot (cfg_slot),
        .wr_data (wr_rec),
        .cfg     (cfg)
    );

    ppk_sorter #(.NUM_PLANES(NUM_PLANES)) u_sort (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .busy      (sort_busy),
        .sort_done (sort_done),
        .order     (order),
        .count     (count)
    );

    ppk_pack #(.NUM_PLANES(NUM_PLANES), .WORD_W(WORD_W)) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (cfg),
        .order         (order),
        .count         (count),
        .fixed_map     (fixed_map),
        .fixed_gen_new (fixed_gen_new),
        .chan_odd      (chan_is_odd),
        .commit        (sort_done),
        .setup_clr     (setup_ok),
        .mask_next     (mask_next),
        .prio_word     (prio_word),
        .plane_mask    (plane_mask)
    );

    ppk_assign #(.HALF_W(HALF_W)) u_asg (
        .clk             (clk),
        .rst_n           (rst_n),
        .commit          (sort_done),
        .chan_odd        (chan_is_odd),
        .mask_next       (mask_next),
        .group_in_use    (group_in_use),
        .restart_pending (restart_pending),
        .assign_word     (assign_word),
        .restart_req     (restart_req)
    );

    // Purpose: done marks the cycle the new outputs are visible.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= sort_done;
    end

    // done is a single-cycle pulse.
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done stretched"); // R11
    // A restart request never appears outside a done cycle.
    AST_RESTART_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> done) else $error("restart outside done"); // R8

endmodule

// File: tb/test_plane_prio_packer.sv
// Bench for plane_prio_packer: a vector table walked by one loop, then
// directed tests for reset, setup clear, restart rules and busy behaviour.
module test_plane_prio_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic        cfg_visible = 1'b0, cfg_on_chan = 1'b0, cfg_dual = 1'b0;
    logic [3:0]  cfg_zpos = '0;
    logic [2:0]  cfg_hwidx = '0;
    logic        chan_is_odd = 1'b0, fixed_map = 1'b0, fixed_gen_new = 1'b0;
    logic        group_in_use = 1'b1, restart_pending = 1'b0;
    logic        setup_clr = 1'b0, compute = 1'b0;
    logic        busy, done, restart_req;
    logic [31:0] prio_word, assign_word;
    logic [7:0]  plane_mask;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] bind_m = '0;   // bench model of the binding

    always #2 clk = ~clk;       // 250 MHz

    plane_prio_packer i_plane_prio_packer (
        .clk, .rst_n, .cfg_we, .cfg_slot, .cfg_visible, .cfg_on_chan,
        .cfg_zpos, .cfg_hwidx, .cfg_dual, .chan_is_odd, .fixed_map,
        .fixed_gen_new, .group_in_use, .restart_pending, .setup_clr,
        .compute, .busy, .done, .prio_word, .plane_mask, .assign_word,
        .restart_req
    );

    // Bench record layout: {visible, on_chan, zpos[3:0], hwidx[2:0], dual}
    function automatic logic [9:0] pl(input logic v, input logic o,
                                      input logic [3:0] z, input logic [2:0] h,
                                      input logic d);
        return {v, o, z, h, d};
    endfunction

    localparam logic [9:0] Z = 10'd0;

    typedef struct packed {
        logic [7:0][9:0] pl;      // plane 7 first
        logic            odd;
        logic            fixed;
        logic            gnew;
        logic [31:0]     exp_prio;
        logic [7:0]      exp_mask;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // 0: nothing qualifies (R1, R10)
        '{pl: {Z, Z, Z, Z, Z, Z, pl(1,0,2,1,0), pl(0,1,1,0,0)},
          odd: 1'b0, fixed: 1'b0, gnew: 1'b0, exp_prio: 32'h0, exp_mask: 8'h00},
        // 1: three single planes, out of depth order (R2, R3, R4)
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,3,0,0), pl(1,1,1,6,0), pl(1,1,5,2,0)},
          odd: 1'b1, fixed: 1'b0, gnew: 1'b0, exp_prio: 32'h713, exp_mask: 8'h45},
        // 2: equal depths keep slot order, invisible plane skipped (R1, R2)
        '{pl: {Z, pl(0,1,2,3,0), pl(1,1,0,7,0), Z, pl(1,1,2,1,0), Z, Z, pl(1,1,2,4,0)},
          odd: 1'b1, fixed: 1'b0, gnew: 1'b0, exp_prio: 32'h852, exp_mask: 8'h92},
        // 3: two-plane format wrapping 7 -> 0 (R5)
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,1,3,0), pl(1,1,4,7,1), Z},
          odd: 1'b0, fixed: 1'b0, gnew: 1'b0, exp_prio: 32'h481, exp_mask: 8'h89},
        // 4: sixteen slots, upper ones dropped (R3, R4, R5)
        '{pl: {pl(1,1,0,7,1), pl(1,1,1,6,1), pl(1,1,2,5,1), pl(1,1,3,4,1),
               pl(1,1,4,3,1), pl(1,1,5,2,1), pl(1,1,6,1,1), pl(1,1,7,0,1)},
          odd: 1'b1, fixed: 1'b0, gnew: 1'b0, exp_prio: 32'h45342312, exp_mask: 8'hFF},
        // 5-8: preset mapping (R6)
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,3,0,0), pl(1,1,1,6,0), pl(1,1,5,2,0)},
          odd: 1'b1, fixed: 1'b1, gnew: 1'b0, exp_prio: 32'h2, exp_mask: 8'h02},
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,3,0,0), pl(1,1,1,6,0), pl(1,1,5,2,0)},
          odd: 1'b1, fixed: 1'b1, gnew: 1'b1, exp_prio: 32'h3, exp_mask: 8'h04},
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,3,0,0), pl(1,1,1,6,0), pl(1,1,5,2,0)},
          odd: 1'b0, fixed: 1'b1, gnew: 1'b1, exp_prio: 32'h1, exp_mask: 8'h01},
        '{pl: {Z, Z, Z, Z, Z, pl(1,1,3,0,0), pl(1,1,1,6,0), pl(1,1,5,2,0)},
          odd: 1'b0, fixed: 1'b1, gnew: 1'b0, exp_prio: 32'h1, exp_mask: 8'h01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_plane(input int slot, input logic [9:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 3'(slot);
        {cfg_visible, cfg_on_chan, cfg_zpos, cfg_hwidx, cfg_dual} = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Pulse compute, then wait for done; returns the latency in cycles.
    task automatic run(output int lat);
        @(negedge clk);
        compute = 1'b1;
        @(negedge clk);
        compute = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Bench model of the binding update and restart expectation.
    function automatic logic model_step(input logic odd, input logic [7:0] m);
        logic [15:0] nb;
        nb = odd ? (bind_m | {8'h0, m}) : (bind_m & ~{8'h0, m});
        model_step = ((nb != bind_m) && group_in_use) || restart_pending;
        bind_m = nb;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog act=timeout exp=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        logic exp_rst;
        logic [31:0] keep_prio;
        logic [7:0]  keep_mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 prio", prio_word, 32'h0);
        chk("R12 mask", {24'h0, plane_mask}, 32'h0);
        chk("R12 assign", assign_word, 32'h0);
        chk("R12 done/busy/restart", {29'h0, done, busy, restart_req}, 32'h0);
        // R12: cleared records yield an empty result
        run(lat);
        chk("R12 empty prio", prio_word, 32'h0);
        exp_rst = model_step(1'b0, 8'h00);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 8; s++) wr_plane(s, VECS[v].pl[s]);
            chan_is_odd = VECS[v].odd; fixed_map = VECS[v].fixed;
            fixed_gen_new = VECS[v].gnew;
            run(lat);
            chk($sformatf("R3 R2 R1 prio v%0d", v), prio_word, VECS[v].exp_prio);
            chk($sformatf("R4 R5 R6 R10 mask v%0d", v), {24'h0, plane_mask}, {24'h0, VECS[v].exp_mask});
            chk($sformatf("R11 latency v%0d", v), 32'(lat <= 64), 32'h1);
            exp_rst = model_step(VECS[v].odd, VECS[v].exp_mask);
            chk($sformatf("R7 R8 assign v%0d", v), assign_word, {bind_m, bind_m});
            chk($sformatf("R8 restart v%0d", v), {31'h0, restart_req}, {31'h0, exp_rst});
            @(negedge clk);
            chk($sformatf("R11 done pulse v%0d", v), {30'h0, done, restart_req}, 32'h0);
        end

        // R9: setup clear zeroes the word, keeps mask and binding
        fixed_map = 1'b0; chan_is_odd = 1'b1;
        run(lat);
        exp_rst = model_step(1'b1, 8'h45);
        chk("R9 pre prio", prio_word, 32'h713);
        keep_mask = plane_mask;
        @(negedge clk); setup_clr = 1'b1;
        @(negedge clk); setup_clr = 1'b0;
        chk("R9 prio cleared", prio_word, 32'h0);
        chk("R9 mask kept", {24'h0, plane_mask}, {24'h0, keep_mask});
        chk("R9 assign kept", assign_word, {bind_m, bind_m});

        // R8: change with group idle gives no restart
        for (int s = 0; s < 8; s++) wr_plane(s, VECS[4].pl[s]);
        chan_is_odd = 1'b0; group_in_use = 1'b1;
        run(lat);
        exp_rst = model_step(1'b0, 8'hFF);
        chk("R7 even clears", assign_word, 32'h0);
        group_in_use = 1'b0; chan_is_odd = 1'b1;
        run(lat);
        exp_rst = model_step(1'b1, 8'hFF);
        chk("R8 idle group assign", assign_word, 32'h00FF00FF);
        chk("R8 idle group no restart", {31'h0, restart_req}, 32'h0);
        // R8: pending restart without a change
        restart_pending = 1'b1;
        run(lat);
        exp_rst = model_step(1'b1, 8'hFF);
        chk("R8 pending restart", {31'h0, restart_req}, 32'h1);
        chk("R8 pending no change", assign_word, 32'h00FF00FF);
        restart_pending = 1'b0; group_in_use = 1'b1;

        // R11: writes, compute and setup while busy are ignored
        for (int s = 0; s < 8; s++) wr_plane(s, VECS[1].pl[s]);
        @(negedge clk); compute = 1'b1;
        @(negedge clk); compute = 1'b0;
        chk("R11 busy seen", {31'h0, busy}, 32'h1);
        cfg_we = 1'b1; cfg_slot = 3'd1;
        {cfg_visible, cfg_on_chan, cfg_zpos, cfg_hwidx, cfg_dual} = pl(1,1,9,5,1);
        compute = 1'b1; setup_clr = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; compute = 1'b0; setup_clr = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        chk("R11 busy result prio", prio_word, 32'h713);
        keep_prio = prio_word;
        lat = 0;
        repeat (80) begin @(negedge clk); if (done) lat++; end
        chk("R11 no second done", 32'(lat), 32'h0);
        chk("R11 held prio", prio_word, keep_prio);
        run(lat);
        chk("R11 write ignored", prio_word, 32'h713);
        chk("R11 mask after ignored write", {24'h0, plane_mask}, 32'h45);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule